// File: doc/BRIEF.md
# Fixed-Point Format Converter

This block re-expresses a stream of fixed-point samples in a second fixed-point format. Total width, fraction width and signedness are set by parameters on both sides. Each sample is first lined up on a common binary point. The block then drops the surplus fraction bits, by truncation or by rounding. Last, it resolves values that the output cannot hold: it can clamp them, keep only their low bits, or keep the low bits and raise a flag.

The quantization mode and the overflow mode are parameters fixed at elaboration. A valid bit travels beside each sample through an optional delay line of `LATENCY` register stages. With `LATENCY` at zero the block is purely combinational. Typical uses are narrowing a datapath after a multiplier or an accumulator, widening a sample before arithmetic, and moving between signed and unsigned domains.

Top module: `fxp_convert`

## Requirements
- R1: A sample whose value fits the output format exactly is reproduced with the same numeric value, whatever the two binary-point positions are.
- R2: With `ROUND_EN`=0, fraction bits below the output LSB are discarded, so every result rounds toward negative infinity (raw -1/64 into 4 fraction bits gives -1/16).
- R3: With `ROUND_EN`=1, the nearest output value is chosen, and exact halves go away from zero (1.5 gives 2, and -2.5 LSB gives -3 LSB).
- R4: The range test is applied to the rounded value, so a rounding carry that leaves the range is treated as overflow.
- R5: With `OVF_MODE`=1 (saturate), a value above the range gives the largest output code and a value below it gives the smallest.
- R6: With `OVF_MODE`=0 (wrap), the output is the low `OUT_W` bits of the quantized value.
- R7: With `OVF_MODE`=2 (flag), the output holds the wrapped value and `out_ovf` is 1 for that sample.
- R8: `out_ovf` is 1 only with `out_valid`, and it stays 0 in the wrap and saturate modes.
- R9: `out_valid` equals `in_valid` delayed by `LATENCY` clock cycles, and `out_data` stays aligned with it.
- R10: While reset is held, and after its release until the first sample arrives, a registered converter drives `out_valid`, `out_ovf` and `out_data` to 0.
- R11: The signedness of each side is honoured. A signed input is sign-extended and an unsigned input is zero-padded. For an unsigned output, a negative rounded value is out of range, and in saturate mode it gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | IN_W | Input sample, `IN_FRAC` fraction bits |
| in_valid | input | 1 | Input sample qualifier |
| out_data | output | OUT_W | Converted sample, `OUT_FRAC` fraction bits |
| out_valid | output | 1 | Output sample qualifier |
| out_ovf | output | 1 | Out-of-range indication (flag mode) |

## Verification
The interaction that matters most is rounding combined with overflow in the same sample. A value just below the top of the range carries past the largest code when its half LSB is added, so quantization and the range test act on the same sample. Directed inputs of this kind, such as 63.5 LSB into a 7-bit signed output, are combined with random samples near the range limits. Each result is judged against a real-number model that rounds first and only then applies the clamp, the wrap or the flag.

// File: rtl/fxp_convert.sv
module fxp_convert #(
  parameter int IN_W       = 12,
  parameter int IN_FRAC    = 6,
  parameter int IN_SIGNED  = 1,
  parameter int OUT_W      = 7,
  parameter int OUT_FRAC   = 4,
  parameter int OUT_SIGNED = 1,
  parameter int ROUND_EN   = 1,
  parameter int OVF_MODE   = 1,
  parameter int LATENCY    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IN_W-1:0]  in_data,
  input  logic             in_valid,
  output logic [OUT_W-1:0] out_data,
  output logic             out_valid,
  output logic             out_ovf
);

  localparam int IN_INT  = (IN_W  > IN_FRAC)  ? IN_W  - IN_FRAC  : 1;
  localparam int OUT_INT = (OUT_W > OUT_FRAC) ? OUT_W - OUT_FRAC : 1;
  localparam int MAX_INT = (IN_INT > OUT_INT) ? IN_INT : OUT_INT;
  localparam int FR      = ((IN_FRAC > OUT_FRAC) ? IN_FRAC : OUT_FRAC) + 1;
  localparam int WW      = MAX_INT + FR + 3;
  localparam int SH_IN   = FR - IN_FRAC;
  localparam int DROP    = FR - OUT_FRAC;

  localparam logic signed [WW-1:0] ONE_W = WW'(1);
  localparam logic signed [WW-1:0] HI = (OUT_SIGNED != 0) ?
      (ONE_W <<< (OUT_W - 1)) - ONE_W : (ONE_W <<< OUT_W) - ONE_W;
  localparam logic signed [WW-1:0] LO = (OUT_SIGNED != 0) ?
      -(ONE_W <<< (OUT_W - 1)) : '0;
  localparam logic signed [WW-1:0] HALF = ONE_W <<< (DROP - 1);

  logic signed [WW-1:0] widened, aligned, rnd_add, biased, q;
  logic                 neg, over_hi, under_lo;
  logic [OUT_W-1:0]     res;
  logic                 ovf_now;

  if (IN_SIGNED != 0) begin : g_sext
    assign widened = {{(WW-IN_W){in_data[IN_W-1]}}, in_data};
  end else begin : g_zext
    assign widened = {{(WW-IN_W){1'b0}}, in_data};
  end

  assign aligned = widened <<< SH_IN;
  assign neg     = aligned[WW-1];

  if (ROUND_EN != 0) begin : g_round
    assign rnd_add = HALF - {{(WW-1){1'b0}}, neg};
  end else begin : g_trunc
    assign rnd_add = '0;
  end

  assign biased   = aligned + rnd_add;
  assign q        = biased >>> DROP;
  assign over_hi  = q > HI;
  assign under_lo = q < LO;

  always_comb begin
    res = q[OUT_W-1:0];
    if (OVF_MODE == 1) begin
      if (over_hi)       res = HI[OUT_W-1:0];
      else if (under_lo) res = LO[OUT_W-1:0];
    end
  end

  assign ovf_now = (OVF_MODE == 2) && in_valid && (over_hi || under_lo);

  if (LATENCY == 0) begin : g_comb
    assign out_data  = res;
    assign out_valid = in_valid;
    assign out_ovf   = ovf_now;
  end else begin : g_pipe
    logic [OUT_W-1:0] d_sr [LATENCY];
    logic [LATENCY-1:0] v_sr, o_sr;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < LATENCY; i++) d_sr[i] <= '0;
        v_sr <= '0;
        o_sr <= '0;
      end else begin
        d_sr[0] <= res;
        v_sr[0] <= in_valid;
        o_sr[0] <= ovf_now;
        for (int i = 1; i < LATENCY; i++) begin
          d_sr[i] <= d_sr[i-1];
          v_sr[i] <= v_sr[i-1];
          o_sr[i] <= o_sr[i-1];
        end
      end
    end

    assign out_data  = d_sr[LATENCY-1];
    assign out_valid = v_sr[LATENCY-1];
    assign out_ovf   = o_sr[LATENCY-1];
  end

endmodule

// File: rtl/fxp_convert_chk.sv
module fxp_convert_chk #(
  parameter int IN_W       = 12,
  parameter int OUT_W      = 7,
  parameter int OVF_MODE   = 1,
  parameter int LATENCY    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IN_W-1:0]  in_data,
  input logic             in_valid,
  input logic [OUT_W-1:0] out_data,
  input logic             out_valid,
  input logic             out_ovf
);

  logic sh_v, sh_z;

  if (LATENCY == 0) begin : g_c0
    assign sh_v = in_valid;
    assign sh_z = (in_data == '0);
  end else begin : g_cp
    logic [LATENCY-1:0] v_sh, z_sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_sh <= '0;
        z_sh <= '0;
      end else begin
        v_sh[0] <= in_valid;
        z_sh[0] <= (in_data == '0);
        for (int i = 1; i < LATENCY; i++) begin
          v_sh[i] <= v_sh[i-1];
          z_sh[i] <= z_sh[i-1];
        end
      end
    end
    assign sh_v = v_sh[LATENCY-1];
    assign sh_z = z_sh[LATENCY-1];

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid && !out_ovf)); // R10
  end

  AST_OVF_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_ovf |-> (out_valid && OVF_MODE == 2)); // R8

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == sh_v); // R9

  AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_v && sh_z) |-> (out_data == '0 && !out_ovf)); // R1

endmodule

bind fxp_convert fxp_convert_chk #(
  .IN_W(IN_W), .OUT_W(OUT_W), .OVF_MODE(OVF_MODE), .LATENCY(LATENCY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
  .out_data(out_data), .out_valid(out_valid), .out_ovf(out_ovf)
);

// File: tb/fxp_convert_bench.sv
`timescale 1ns/1ps
module fxp_convert_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;

  logic [11:0] in_ab = '0;
  logic [11:0] in_c  = '0;
  logic [9:0]  in_d  = '0;
  logic [7:0]  in_e  = '0;
  logic        vin   = 1'b0;

  logic [6:0] a_d, b_d;
  logic [5:0] c_d, d_d;
  logic [11:0] e_d;
  logic a_v, b_v, c_v, d_v, e_v, a_o, b_o, c_o, d_o, e_o;

  // A: FIX_12_6 -> FIX_7_4, round, saturate, latency 2
  fxp_convert u_fxp_convert (.clk(clk), .rst_n(rst_n), .in_data(in_ab), .in_valid(vin),
    .out_data(a_d), .out_valid(a_v), .out_ovf(a_o));
  // B: FIX_12_6 -> FIX_7_4, truncate, wrap, latency 0
  fxp_convert #(.ROUND_EN(0), .OVF_MODE(0), .LATENCY(0)) u_fxp_convert_b (.clk(clk), .rst_n(rst_n),
    .in_data(in_ab), .in_valid(vin), .out_data(b_d), .out_valid(b_v), .out_ovf(b_o));
  // C: FIX_12_4 -> FIX_6_0, round, flag, latency 1
  fxp_convert #(.IN_FRAC(4), .OUT_W(6), .OUT_FRAC(0), .OVF_MODE(2), .LATENCY(1)) u_fxp_convert_c (
    .clk(clk), .rst_n(rst_n), .in_data(in_c), .in_valid(vin),
    .out_data(c_d), .out_valid(c_v), .out_ovf(c_o));
  // D: FIX_10_8 -> UFIX_6_2, round, saturate, latency 1
  fxp_convert #(.IN_W(10), .IN_FRAC(8), .OUT_W(6), .OUT_FRAC(2), .OUT_SIGNED(0), .LATENCY(1))
    u_fxp_convert_d (.clk(clk), .rst_n(rst_n), .in_data(in_d), .in_valid(vin),
    .out_data(d_d), .out_valid(d_v), .out_ovf(d_o));
  // E: UFIX_8_4 -> FIX_12_6, truncate, wrap, latency 0
  fxp_convert #(.IN_W(8), .IN_FRAC(4), .IN_SIGNED(0), .OUT_W(12), .OUT_FRAC(6), .ROUND_EN(0),
    .OVF_MODE(0), .LATENCY(0)) u_fxp_convert_e (.clk(clk), .rst_n(rst_n), .in_data(in_e),
    .in_valid(vin), .out_data(e_d), .out_valid(e_v), .out_ovf(e_o));

  function automatic longint sval(longint bits, int w, bit s);
    if (s && bits[w-1]) return bits - (longint'(1) << w);
    return bits;
  endfunction

  function automatic longint model(longint raw, int in_frac, int out_w, int out_frac,
                                   bit out_s, bit rnd, int mode, output bit ovf);
    real y, r;
    longint q, hi, lo;
    y = real'(raw) * (2.0 ** real'(out_frac - in_frac));
    if (!rnd)        r = $floor(y);
    else if (y >= 0) r = $floor(y + 0.5);
    else             r = -$floor(-y + 0.5);
    q  = longint'(r);
    hi = out_s ? (longint'(1) << (out_w - 1)) - 1 : (longint'(1) << out_w) - 1;
    lo = out_s ? -(longint'(1) << (out_w - 1)) : 0;
    ovf = (mode == 2) && (q > hi || q < lo);
    if (mode == 1) begin
      if (q > hi) q = hi;
      else if (q < lo) q = lo;
    end
    return q & ((longint'(1) << out_w) - 1);
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_outs(string ra, string rb, string rc, string rd, string re);
    bit o;
    longint e;
    e = model(sval(in_ab, 12, 1), 6, 7, 4, 1, 1, 1, o);
    chk(ra, "A data", a_d, e); chk("R8", "A ovf", a_o, o); chk("R9", "A valid", a_v, vin);
    e = model(sval(in_ab, 12, 1), 6, 7, 4, 1, 0, 0, o);
    chk(rb, "B data", b_d, e); chk("R8", "B ovf", b_o, o);
    e = model(sval(in_c, 12, 1), 4, 6, 0, 1, 1, 2, o);
    chk(rc, "C data", c_d, e); chk("R7", "C ovf", c_o, o);
    e = model(sval(in_d, 10, 1), 8, 6, 2, 0, 1, 1, o);
    chk(rd, "D data", d_d, e); chk("R8", "D ovf", d_o, o);
    e = model(sval(in_e, 8, 0), 4, 12, 6, 1, 0, 0, o);
    chk(re, "E data", e_d, e); chk("R8", "E ovf", e_o, o);
  endtask

  task automatic apply(logic [11:0] a, logic [11:0] c, logic [9:0] d, logic [7:0] e,
                       string ra, string rb, string rc, string rd, string re);
    @(negedge clk);
    in_ab = a; in_c = c; in_d = d; in_e = e; vin = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_outs(ra, rb, rc, rd, re);
  endtask

  logic [11:0] hist [64];
  bit done = 1'b0;

  initial begin
    #200000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk);
    // R10: registered outputs idle during reset
    chk("R10", "A valid rst", a_v, 0); chk("R10", "A data rst", a_d, 0);
    chk("R10", "C ovf rst", c_o, 0);   chk("R10", "C data rst", c_d, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "A valid after rst", a_v, 0);
    chk("R10", "D valid after rst", d_v, 0);

    // directed corner cases
    apply(12'd876, 12'd24, 10'd0, 8'd255, "R5", "R6", "R3", "R1", "R11");
    apply(12'd254, 12'd640, -10'sd77, 8'd0, "R4", "R2", "R7", "R11", "R1");
    apply(-12'sd10, -12'sd7, 10'd511, 8'd17, "R3", "R2", "R3", "R11", "R1");
    apply(-12'sd1, 12'd2047, -10'sd512, 8'd128, "R3", "R2", "R7", "R11", "R11");
    apply(12'd0, 12'd0, 10'd0, 8'd0, "R1", "R1", "R1", "R1", "R1");
    apply(-12'sd2048, -12'sd2048, 10'd6, 8'd1, "R5", "R6", "R7", "R3", "R1");
    apply(12'd128, 12'd40, 10'd96, 8'd3, "R1", "R1", "R3", "R3", "R1");

    // random sweep across all converters
    for (int i = 0; i < 300; i++) begin
      apply(12'($urandom), 12'($urandom), 10'($urandom), 8'($urandom),
            "R5", "R6", "R7", "R11", "R1");
    end

    // R9: single valid pulse
    @(negedge clk);
    vin = 1'b0;
    repeat (4) @(negedge clk);
    in_ab = 12'd100; vin = 1'b1;
    #1 chk("R9", "B valid lat0", b_v, 1);
    @(negedge clk);
    vin = 1'b0;
    chk("R9", "A valid +1", a_v, 0); chk("R9", "C valid +1", c_v, 1);
    @(negedge clk);
    chk("R9", "A valid +2", a_v, 1); chk("R9", "C valid +2", c_v, 0);
    chk("R9", "A data +2", a_d, 7'd25);
    @(negedge clk);
    chk("R9", "A valid +3", a_v, 0);

    // R9: streaming alignment on A
    for (int k = 0; k < 40; k++) begin
      bit o;
      if (k >= 2) chk("R9", "A stream", a_d,
                      model(sval(hist[k-2], 12, 1), 6, 7, 4, 1, 1, 1, o));
      hist[k] = 12'($urandom);
      in_ab = hist[k]; vin = 1'b1;
      @(negedge clk);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule